// File: doc/BRIEF.md
# Set-Associative Instruction Address Translator

This block maps instruction-fetch virtual addresses to physical addresses through a small set-associative translation buffer. Each way holds, for every set, a tag word and a mapping word. The tag word carries the virtual page tag, a valid bit and a two-bit age. The mapping word carries the physical page, a cache-inhibit bit and two execute permissions, one for supervisor mode and one for user mode. A lookup request gives a virtual address together with three status bits: translation enabled, translator present and supervisor mode. One cycle later the block returns the physical address, a cache-inhibit flag and hit, miss and page-fault flags.

When translation is off, or the translator is marked absent, the address passes through unchanged. In that case cache-inhibit follows the top address bit. A request that finds no valid matching way reports a miss, so that miss-handler software can refill an entry. Entries are loaded, and can be read back, through a synchronous register port addressed by way, set and word select. The ages in a set count down as that set is hit, which gives a replacement handler the recency order.

Top module: `itlb_xlate`

## Requirements
- R1: When the enable input or the present input is low, the response returns the request address unchanged as the physical address, with hit, miss and fault all low.
- R2: In that pass-through case, cache-inhibit is high exactly when address bit 31 is set (address at or above 0x80000000).
- R3: `resp_valid_o` is high in the cycle after a cycle with `req_valid_i` high, and low otherwise. All response fields are registered.
- R4: The set index is the address bits just above the 13-bit page offset, which are bits [14:13] for 4 sets. A way hits when its valid bit (tag word bit 0) is set and its stored tag (tag word bits [31:13]) equals the address above both the offset and the set bits. Among several matching ways, the lowest-numbered way wins.
- R5: On a hit, the physical address is the mapping word's page field (bits [31:13]) joined with address bits [12:0]. Cache-inhibit is mapping word bit 1.
- R6: On a hit in supervisor mode, fault is raised when mapping word bit 6 (supervisor execute) is clear. In user mode, fault is raised when bit 7 (user execute) is clear.
- R7: A translated request with no valid match reports miss, with hit, fault, cache-inhibit and the physical address all zero. Miss and fault are never high together.
- R8: On a hit, every other way in the set with a nonzero age (tag word bits [7:6]) is decremented by one. A way whose age is zero stays at zero.
- R9: On a hit, the hit way's age is loaded with the reload value: the low two bits of the set count minus one, which is 3 for 4 sets.
- R10: A miss, a pass-through request or an idle cycle leaves every age unchanged.
- R11: Reset clears every stored word, including all valid bits. A write with select 0 loads the tag word and a write with select 1 loads the mapping word. Read-back returns the stored fields in the same bit positions, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Lookup request strobe |
| vaddr_i | input | 32 | Virtual fetch address |
| xlate_en_i | input | 1 | Translation enabled |
| xlate_present_i | input | 1 | Translator present |
| supervisor_i | input | 1 | Request made in supervisor mode |
| resp_valid_o | output | 1 | Response valid |
| paddr_o | output | 32 | Physical address |
| ci_o | output | 1 | Cache-inhibit |
| hit_o | output | 1 | Translation hit |
| miss_o | output | 1 | No valid matching way |
| fault_o | output | 1 | Execute permission fault |
| wr_en_i | input | 1 | Entry write strobe |
| wr_way_i | input | 1 | Entry write way |
| wr_set_i | input | 2 | Entry write set |
| wr_sel_i | input | 1 | 0 selects the tag word, 1 the mapping word |
| wr_data_i | input | 32 | Entry write data |
| rd_way_i | input | 1 | Read-back way |
| rd_set_i | input | 2 | Read-back set |
| rd_sel_i | input | 1 | 0 selects the tag word, 1 the mapping word |
| rd_data_o | output | 32 | Read-back data (combinational) |

## Verification
A corrupted tag or valid bit appears in the very next response as a wrong hit or a wrong miss. A corrupted mapping field appears there as a wrong physical page, cache-inhibit value or fault. Age corruption never affects a translation, so the bench reads the ages back after each hit, miss and idle cycle. The first bad decrement or reload is therefore caught one lookup after it happens. Pass-through responses are compared bit for bit against the request address, on both sides of the top-bit boundary.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
  localparam int unsigned AGE_LO   = 6;
  localparam int unsigned AGE_W    = 2;
  localparam int unsigned VALID_B  = 0;
  localparam int unsigned CI_B     = 1;
  localparam int unsigned SXE_B    = 6;
  localparam int unsigned UXE_B    = 7;
  localparam int unsigned FIELD_HI = 8;  // low bits used by flags; offset must exceed this

  typedef enum logic {
    SEL_TAG = 1'b0,
    SEL_MAP = 1'b1
  } word_sel_e;
endpackage

// File: rtl/itlb_store.sv
module itlb_store
  import itlb_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned OFF_W = 13,
  parameter int unsigned SETS  = 4,
  parameter int unsigned WAYS  = 2,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int unsigned VPN_W = VA_W - OFF_W
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         wr_en_i,
  input  logic [WAY_W-1:0]             wr_way_i,
  input  logic [SET_W-1:0]             wr_set_i,
  input  logic                         wr_sel_i,
  input  logic [VA_W-1:0]              wr_data_i,
  input  logic                         upd_en_i,
  input  logic [SET_W-1:0]             upd_set_i,
  input  logic [WAY_W-1:0]             upd_way_i,
  input  logic [SET_W-1:0]             look_set_i,
  output logic [WAYS-1:0][VPN_W-1:0]   look_vpn_o,
  output logic [WAYS-1:0]              look_valid_o,
  output logic [WAYS-1:0][VPN_W-1:0]   look_ppn_o,
  output logic [WAYS-1:0]              look_ci_o,
  output logic [WAYS-1:0]              look_sxe_o,
  output logic [WAYS-1:0]              look_uxe_o,
  input  logic [WAY_W-1:0]             rd_way_i,
  input  logic [SET_W-1:0]             rd_set_i,
  input  logic                         rd_sel_i,
  output logic [VA_W-1:0]              rd_data_o
);
  localparam logic [AGE_W-1:0] RELOAD = AGE_W'(SETS - 1);

  logic [WAYS-1:0][SETS-1:0][VPN_W-1:0] vpn_q, ppn_q;
  logic [WAYS-1:0][SETS-1:0][AGE_W-1:0] age_q;
  logic [WAYS-1:0][SETS-1:0]            valid_q, ci_q, sxe_q, uxe_q;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vpn_q[w]   <= '0;
        ppn_q[w]   <= '0;
        age_q[w]   <= '0;
        valid_q[w] <= '0;
        ci_q[w]    <= '0;
        sxe_q[w]   <= '0;
        uxe_q[w]   <= '0;
      end else begin
        for (int s = 0; s < SETS; s++) begin
          // age update on hit; a write to the same tag word takes priority
          if (upd_en_i && upd_set_i == SET_W'(s)) begin
            if (upd_way_i == WAY_W'(w))  age_q[w][s] <= RELOAD;
            else if (age_q[w][s] != '0)  age_q[w][s] <= age_q[w][s] - 1'b1;
          end
          if (wr_en_i && wr_way_i == WAY_W'(w) && wr_set_i == SET_W'(s)) begin
            if (wr_sel_i == SEL_TAG) begin
              vpn_q[w][s]   <= wr_data_i[VA_W-1:OFF_W];
              age_q[w][s]   <= wr_data_i[AGE_LO +: AGE_W];
              valid_q[w][s] <= wr_data_i[VALID_B];
            end else begin
              ppn_q[w][s] <= wr_data_i[VA_W-1:OFF_W];
              ci_q[w][s]  <= wr_data_i[CI_B];
              sxe_q[w][s] <= wr_data_i[SXE_B];
              uxe_q[w][s] <= wr_data_i[UXE_B];
            end
          end
        end
      end
    end

    assign look_vpn_o[w]   = vpn_q[w][look_set_i];
    assign look_valid_o[w] = valid_q[w][look_set_i];
    assign look_ppn_o[w]   = ppn_q[w][look_set_i];
    assign look_ci_o[w]    = ci_q[w][look_set_i];
    assign look_sxe_o[w]   = sxe_q[w][look_set_i];
    assign look_uxe_o[w]   = uxe_q[w][look_set_i];
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_sel_i == SEL_TAG) begin
      rd_data_o[VA_W-1:OFF_W]      = vpn_q[rd_way_i][rd_set_i];
      rd_data_o[AGE_LO +: AGE_W]   = age_q[rd_way_i][rd_set_i];
      rd_data_o[VALID_B]           = valid_q[rd_way_i][rd_set_i];
    end else begin
      rd_data_o[VA_W-1:OFF_W]      = ppn_q[rd_way_i][rd_set_i];
      rd_data_o[CI_B]              = ci_q[rd_way_i][rd_set_i];
      rd_data_o[SXE_B]             = sxe_q[rd_way_i][rd_set_i];
      rd_data_o[UXE_B]             = uxe_q[rd_way_i][rd_set_i];
    end
  end
endmodule

// File: rtl/itlb_match.sv
module itlb_match #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned OFF_W = 13,
  parameter int unsigned SETS  = 4,
  parameter int unsigned WAYS  = 2,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int unsigned VPN_W = VA_W - OFF_W,
  localparam int unsigned TAG_W = VPN_W - SET_W
) (
  input  logic [VA_W-1:0]            vaddr_i,
  input  logic [WAYS-1:0][VPN_W-1:0] vpn_i,
  input  logic [WAYS-1:0]            valid_i,
  input  logic [WAYS-1:0][VPN_W-1:0] ppn_i,
  input  logic [WAYS-1:0]            ci_i,
  input  logic [WAYS-1:0]            sxe_i,
  input  logic [WAYS-1:0]            uxe_i,
  output logic                       hit_o,
  output logic [WAY_W-1:0]           way_o,
  output logic [VPN_W-1:0]           ppn_o,
  output logic                       ci_o,
  output logic                       sxe_o,
  output logic                       uxe_o
);
  logic [WAYS-1:0] eq;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign eq[w] = valid_i[w] &&
                   (vpn_i[w][VPN_W-1:SET_W] == vaddr_i[VA_W-1 -: TAG_W]);
  end

  // lowest way wins: scan downward so it is assigned last
  always_comb begin
    hit_o = 1'b0;
    way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (eq[w]) begin
        hit_o = 1'b1;
        way_o = WAY_W'(w);
      end
    end
    ppn_o = ppn_i[way_o];
    ci_o  = ci_i[way_o];
    sxe_o = sxe_i[way_o];
    uxe_o = uxe_i[way_o];
  end
endmodule

// File: rtl/itlb_xlate.sv
module itlb_xlate
  import itlb_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned OFF_W = 13,
  parameter int unsigned SETS  = 4,
  parameter int unsigned WAYS  = 2,
  localparam int unsigned SET_W = $clog2(SETS),
  localparam int unsigned WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int unsigned VPN_W = VA_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   vaddr_i,
  input  logic              xlate_en_i,
  input  logic              xlate_present_i,
  input  logic              supervisor_i,
  output logic              resp_valid_o,
  output logic [VA_W-1:0]   paddr_o,
  output logic              ci_o,
  output logic              hit_o,
  output logic              miss_o,
  output logic              fault_o,
  input  logic              wr_en_i,
  input  logic [WAY_W-1:0]  wr_way_i,
  input  logic [SET_W-1:0]  wr_set_i,
  input  logic              wr_sel_i,
  input  logic [VA_W-1:0]   wr_data_i,
  input  logic [WAY_W-1:0]  rd_way_i,
  input  logic [SET_W-1:0]  rd_set_i,
  input  logic              rd_sel_i,
  output logic [VA_W-1:0]   rd_data_o
);
  logic [SET_W-1:0]            set_idx;
  logic [WAYS-1:0][VPN_W-1:0]  l_vpn, l_ppn;
  logic [WAYS-1:0]             l_valid, l_ci, l_sxe, l_uxe;
  logic                        m_hit, m_ci, m_sxe, m_uxe;
  logic [WAY_W-1:0]            m_way;
  logic [VPN_W-1:0]            m_ppn;
  logic                        bypass, do_xlate, upd_en;

  assign set_idx  = vaddr_i[OFF_W +: SET_W];
  assign bypass   = !(xlate_en_i && xlate_present_i);
  assign do_xlate = req_valid_i && !bypass;
  assign upd_en   = do_xlate && m_hit;

  itlb_store #(.VA_W(VA_W), .OFF_W(OFF_W), .SETS(SETS), .WAYS(WAYS)) u_store (
    .clk_i, .rst_ni,
    .wr_en_i, .wr_way_i, .wr_set_i, .wr_sel_i, .wr_data_i,
    .upd_en_i(upd_en), .upd_set_i(set_idx), .upd_way_i(m_way),
    .look_set_i(set_idx),
    .look_vpn_o(l_vpn), .look_valid_o(l_valid), .look_ppn_o(l_ppn),
    .look_ci_o(l_ci), .look_sxe_o(l_sxe), .look_uxe_o(l_uxe),
    .rd_way_i, .rd_set_i, .rd_sel_i, .rd_data_o
  );

  itlb_match #(.VA_W(VA_W), .OFF_W(OFF_W), .SETS(SETS), .WAYS(WAYS)) u_match (
    .vaddr_i, .vpn_i(l_vpn), .valid_i(l_valid), .ppn_i(l_ppn),
    .ci_i(l_ci), .sxe_i(l_sxe), .uxe_i(l_uxe),
    .hit_o(m_hit), .way_o(m_way), .ppn_o(m_ppn),
    .ci_o(m_ci), .sxe_o(m_sxe), .uxe_o(m_uxe)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      paddr_o      <= '0;
      ci_o         <= 1'b0;
      hit_o        <= 1'b0;
      miss_o       <= 1'b0;
      fault_o      <= 1'b0;
    end else begin
      resp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        if (bypass) begin
          paddr_o <= vaddr_i;
          ci_o    <= vaddr_i[VA_W-1];
          hit_o   <= 1'b0;
          miss_o  <= 1'b0;
          fault_o <= 1'b0;
        end else if (m_hit) begin
          paddr_o <= {m_ppn, vaddr_i[OFF_W-1:0]};
          ci_o    <= m_ci;
          hit_o   <= 1'b1;
          miss_o  <= 1'b0;
          fault_o <= supervisor_i ? !m_sxe : !m_uxe;
        end else begin
          paddr_o <= '0;
          ci_o    <= 1'b0;
          hit_o   <= 1'b0;
          miss_o  <= 1'b1;
          fault_o <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/itlb_xlate_chk.sv
module itlb_xlate_chk #(
  parameter int unsigned VA_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic [VA_W-1:0] vaddr_i,
  input logic            xlate_en_i,
  input logic            xlate_present_i,
  input logic            resp_valid_o,
  input logic [VA_W-1:0] paddr_o,
  input logic            ci_o,
  input logic            hit_o,
  input logic            miss_o,
  input logic            fault_o
);
  logic pass_req;
  assign pass_req = req_valid_i && !(xlate_en_i && xlate_present_i);

  a_r1_pass_identity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_req |=> resp_valid_o && paddr_o == $past(vaddr_i) && !hit_o && !miss_o && !fault_o);

  a_r2_pass_ci: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_req |=> ci_o == $past(vaddr_i[VA_W-1]));

  a_r3_req_gives_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> resp_valid_o);

  a_r3_no_idle_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !resp_valid_o);

  a_r6_fault_needs_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> hit_o);

  a_r7_miss_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> !fault_o && !hit_o && !ci_o && paddr_o == '0);
endmodule

bind itlb_xlate itlb_xlate_chk #(.VA_W(VA_W)) u_chk (
  .clk_i, .rst_ni, .req_valid_i, .vaddr_i, .xlate_en_i, .xlate_present_i,
  .resp_valid_o, .paddr_o, .ci_o, .hit_o, .miss_o, .fault_o
);

// File: tb/itlb_xlate_tb.sv
`timescale 1ns/1ps
module itlb_xlate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, en = 1'b0, pres = 1'b0, sup = 1'b0;
  logic [31:0] va = '0;
  logic        resp_valid, ci, hit, miss, fault;
  logic [31:0] pa;
  logic        wr_en = 1'b0, wr_way = 1'b0, wr_sel = 1'b0;
  logic [1:0]  wr_set = '0;
  logic [31:0] wr_data = '0;
  logic        rd_way = 1'b0, rd_sel = 1'b0;
  logic [1:0]  rd_set = '0;
  logic [31:0] rd_data;
  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  itlb_xlate u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req), .vaddr_i(va),
    .xlate_en_i(en), .xlate_present_i(pres), .supervisor_i(sup),
    .resp_valid_o(resp_valid), .paddr_o(pa), .ci_o(ci), .hit_o(hit),
    .miss_o(miss), .fault_o(fault),
    .wr_en_i(wr_en), .wr_way_i(wr_way), .wr_set_i(wr_set), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .rd_way_i(rd_way), .rd_set_i(rd_set),
    .rd_sel_i(rd_sel), .rd_data_o(rd_data)
  );

  typedef struct packed {
    logic [31:0] va;
    logic        en, pres, sup;
    logic [31:0] pa;
    logic        ci, hit, miss, fault;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'h7FFF_FFFC, 1'b0, 1'b1, 1'b1, 32'h7FFF_FFFC, 1'b0, 1'b0, 1'b0, 1'b0}, // R1 R2
    '{32'h8000_0010, 1'b0, 1'b1, 1'b0, 32'h8000_0010, 1'b1, 1'b0, 1'b0, 1'b0}, // R1 R2
    '{32'h8000_0010, 1'b1, 1'b0, 1'b1, 32'h8000_0010, 1'b1, 1'b0, 1'b0, 1'b0}, // R1 present low
    '{32'h1234_2ABC, 1'b1, 1'b1, 1'b1, 32'h0ABC_EABC, 1'b1, 1'b1, 1'b0, 1'b0}, // R5
    '{32'h1234_2ABC, 1'b1, 1'b1, 1'b0, 32'h0ABC_EABC, 1'b1, 1'b1, 1'b0, 1'b1}, // R6 user
    '{32'h1234_0ABC, 1'b1, 1'b1, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 other set
    '{32'h1234_AABC, 1'b1, 1'b1, 1'b1, 32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b0}, // R4 tag bit 15
    '{32'h5555_3FF0, 1'b1, 1'b1, 1'b0, 32'h0010_1FF0, 1'b0, 1'b1, 1'b0, 1'b0}, // R5 R6
    '{32'h5555_3FF0, 1'b1, 1'b1, 1'b1, 32'h0010_1FF0, 1'b0, 1'b1, 1'b0, 1'b1}  // R6 sup
  };

  task automatic check(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  task automatic write_word(input logic way, input logic [1:0] set, input logic sel,
                            input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_way = way; wr_set = set; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_word(input logic way, input logic [1:0] set, input logic sel,
                           output logic [31:0] data);
    rd_way = way; rd_set = set; rd_sel = sel;
    #1;
    data = rd_data;
  endtask

  // response is sampled at the negedge after the capturing posedge
  task automatic lookup(input logic [31:0] a, input logic e, input logic p, input logic s);
    @(negedge clk);
    req = 1'b1; va = a; en = e; pres = p; sup = s;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R3 reset resp_valid", {31'b0, resp_valid}, 32'h0);
    read_word(1'b0, 2'd1, 1'b0, d);
    check("R11 reset tag word", d, 32'h0);
    rst_n = 1'b1;

    // R11 load entries, then read back
    write_word(1'b0, 2'd1, 1'b0, 32'h1234_2001);
    write_word(1'b0, 2'd1, 1'b1, 32'h0ABC_E042);
    write_word(1'b1, 2'd1, 1'b0, 32'h5555_2001);
    write_word(1'b1, 2'd1, 1'b1, 32'h0010_0080);
    read_word(1'b0, 2'd1, 1'b1, d);
    check("R11 mapping readback", d, 32'h0ABC_E042);
    read_word(1'b1, 2'd1, 1'b0, d);
    check("R11 tag readback", d, 32'h5555_2001);

    for (int i = 0; i < NV; i++) begin
      lookup(VECS[i].va, VECS[i].en, VECS[i].pres, VECS[i].sup);
      check("R3 resp_valid", {31'b0, resp_valid}, 32'h1);
      check("R1 R5 R7 paddr", pa, VECS[i].pa);
      check("R2 R5 ci", {31'b0, ci}, {31'b0, VECS[i].ci});
      check("R4 hit", {31'b0, hit}, {31'b0, VECS[i].hit});
      check("R7 miss", {31'b0, miss}, {31'b0, VECS[i].miss});
      check("R6 fault", {31'b0, fault}, {31'b0, VECS[i].fault});
    end
    @(negedge clk);
    check("R3 idle no resp", {31'b0, resp_valid}, 32'h0);

    // R8 R9 aging: way0 age 2, way1 age 0
    write_word(1'b0, 2'd1, 1'b0, 32'h1234_2081);
    write_word(1'b1, 2'd1, 1'b0, 32'h5555_2001);
    lookup(32'h5555_3FF0, 1'b1, 1'b1, 1'b0);
    read_word(1'b0, 2'd1, 1'b0, d);
    check("R8 other way decremented", d, 32'h1234_2041);
    read_word(1'b1, 2'd1, 1'b0, d);
    check("R9 hit way reloaded", d, 32'h5555_20C1);
    lookup(32'h1234_2000, 1'b1, 1'b1, 1'b1);
    read_word(1'b0, 2'd1, 1'b0, d);
    check("R9 reload from 1", d, 32'h1234_20C1);
    read_word(1'b1, 2'd1, 1'b0, d);
    check("R8 decrement from 3", d, 32'h5555_2081);
    write_word(1'b1, 2'd1, 1'b0, 32'h5555_2001);
    lookup(32'h1234_2000, 1'b1, 1'b1, 1'b1);
    read_word(1'b1, 2'd1, 1'b0, d);
    check("R8 zero age stays zero", d, 32'h5555_2001);

    // R10 miss, pass-through and idle leave ages alone
    lookup(32'h7777_2000, 1'b1, 1'b1, 1'b1);
    lookup(32'h5555_2000, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    read_word(1'b0, 2'd1, 1'b0, d);
    check("R10 no aging way0", d, 32'h1234_20C1);
    read_word(1'b1, 2'd1, 1'b0, d);
    check("R10 no aging way1", d, 32'h5555_2001);

    // R4 two matching ways: lowest wins
    write_word(1'b1, 2'd1, 1'b0, 32'h1234_2001);
    lookup(32'h1234_2010, 1'b1, 1'b1, 1'b1);
    check("R4 lowest way wins", pa, 32'h0ABC_E010);
    // R4 invalid entries do not match
    write_word(1'b0, 2'd1, 1'b0, 32'h1234_2000);
    write_word(1'b1, 2'd1, 1'b0, 32'h1234_2000);
    lookup(32'h1234_2010, 1'b1, 1'b1, 1'b1);
    check("R4 invalid miss", {31'b0, miss}, 32'h1);
    check("R7 no fault on miss", {31'b0, fault}, 32'h0);

    // R11 reset mid-run clears stored words
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    read_word(1'b1, 2'd1, 1'b1, d);
    check("R11 reset clears mapping", d, 32'h0);
    rst_n = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule